// File: doc/BRIEF.md
# Blit Address Stepper with Tiled Source and Pattern

This block produces the three memory addresses that a rectangular block transfer needs on every pixel: one for the destination, one for the source and one for the pattern. A start pulse captures the start addresses, the per-row pitch values, the rectangle extent, the two direction bits and the tile sizes. After that, each step pulse moves all three addresses to the next pixel. Once the final pixel of the final row has been stepped past, the block drops busy and raises a one-cycle done pulse. It performs no memory access and no pixel combining; those belong to neighbouring logic that consumes the addresses.

Source and pattern may each be confined to a power-of-two tile. The tile width selects how many low address bits form a column index, which cycles inside the tile. The tile height adds a row index that cycles inside the tile and pulls the row address back by a whole tile when it passes an edge. With no tiling, an address advances linearly. The destination is never tiled: every row restarts from the saved start address of the previous row, moved by one pitch. All address arithmetic is modulo 2^AW.

Top module: `blit_addr_stepper`

## Requirements
- R1: While reset is asserted and after it is released, all three addresses read 0, and busy and done are both 0.
- R2: One cycle after start, busy is 1. The destination address equals its start address. A source or pattern address equals its start address, except when both tile codes are non-zero: in that case it equals the start address with its bits from position w up to (w+h-1) cleared, where w and h are the width and height codes.
- R3: A step that does not end a row moves the destination address by +1 when dir_x_neg is 0 and by -1 when it is 1.
- R4: A step that ends a row (the column count has reached x_last) sets the destination to the start address of the row just finished, plus (pitch+1) when dir_y_neg is 0 or minus (pitch+1) when it is 1.
- R5: A tile width code c of 1 to 7 gives a tile width W = 2^c, and code 0 means no tiling. With a non-zero code, the source or pattern column starts at (start address mod W), steps by the X direction, and wraps modulo W. The address is the row address plus the column.
- R6: At every row end, the source and pattern columns return to their starting column, and their row addresses move by ±(pitch+1), with the sign given by dir_y_neg.
- R7: When both tile codes are non-zero (height H = 2^code), the tile row starts at floor(start/W) mod H. When it steps above H-1 it becomes 0 and the row address moves back by (pitch+1)·H. When it steps below 0 it becomes H-1 and the row address moves forward by (pitch+1)·H.
- R8: A rectangle takes (x_last+1)·(y_last+1) pixels. The step taken on the last pixel raises done for exactly one cycle and clears busy, and the addresses keep the last pixel's values.
- R9: Step pulses while busy is 0 change no output.
- R10: Start while busy abandons the current rectangle and reloads from the new settings, even when step is high in the same cycle.
- R11: Every address wraps modulo 2^AW, both when incrementing past the top and when decrementing below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture settings and begin a rectangle |
| step | input | 1 | Advance one pixel while busy |
| dir_x_neg | input | 1 | 1 = pixels step downward in address |
| dir_y_neg | input | 1 | 1 = rows step downward in address |
| x_last | input | CW | Pixels per row minus one |
| y_last | input | CW | Rows minus one |
| dst_base | input | AW | Destination start address |
| dst_pitch | input | AW | Destination row pitch minus one |
| src_base | input | AW | Source start address |
| src_pitch | input | AW | Source row pitch minus one |
| src_wrap_w | input | WCW | Source tile width code (0 = none) |
| src_wrap_h | input | WCW | Source tile height code (0 = none) |
| pat_base | input | AW | Pattern start address |
| pat_pitch | input | AW | Pattern row pitch minus one |
| pat_wrap_w | input | WCW | Pattern tile width code (0 = none) |
| pat_wrap_h | input | WCW | Pattern tile height code (0 = none) |
| dst_addr | output | AW | Current destination address |
| src_addr | output | AW | Current source address |
| pat_addr | output | AW | Current pattern address |
| busy | output | 1 | Rectangle in progress |
| done | output | 1 | One-cycle pulse after the last pixel |

## Verification
The hardest case to reach from the ports is a tile row counter crossing its edge in the negative direction. Reaching it needs a start address whose middle bits put the starting row in the middle of a tile, Y tiling enabled, and enough rows that the counter underflows and then wraps again. The stimulus table therefore includes rectangles whose start rows are non-zero, with both Y directions and with more rows than the tile height. The expected addresses come from a closed-form expression in the pixel and row index, not from a replay of the step-by-step updates. A restart while busy, and steps while idle, are driven as directed cases.

// File: rtl/blit_step_pkg.sv
package blit_step_pkg;
    localparam int WRAP_CODE_W = 3;
    localparam int NUM_CHAN    = 3;

    typedef enum logic [1:0] {
        CH_DST = 2'd0,
        CH_SRC = 2'd1,
        CH_PAT = 2'd2
    } chan_e;

    typedef struct packed {
        logic neg_x;
        logic neg_y;
    } blit_dir_t;
endpackage

// File: rtl/blit_span_ctr.sv
module blit_span_ctr
    import blit_step_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] x_last,
    input  logic [CW-1:0] y_last,
    output logic          adv_x,
    output logic          adv_y,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        logic [CW-1:0] xpos;
        logic [CW-1:0] ypos;
        logic [CW-1:0] xl;
        logic [CW-1:0] yl;
        logic          busy;
        logic          done;
    } ctr_t;

    ctr_t st_d, st_q;
    logic row_end, final_px, take;

    always_comb begin
        row_end  = (st_q.xpos == st_q.xl);
        final_px = row_end && (st_q.ypos == st_q.yl);
        take     = st_q.busy && step && !load;
        adv_x    = take && !row_end;
        adv_y    = take && row_end && !final_px;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (load) begin
            st_d.xpos = '0;
            st_d.ypos = '0;
            st_d.xl   = x_last;
            st_d.yl   = y_last;
            st_d.busy = 1'b1;
        end else if (take) begin
            if (final_px) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else if (row_end) begin
                st_d.xpos = '0;
                st_d.ypos = st_q.ypos + CW'(1);
            end else begin
                st_d.xpos = st_q.xpos + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
endmodule

// File: rtl/blit_chan.sv
module blit_chan
    import blit_step_pkg::*;
#(
    parameter int AW  = 16,
    parameter int WCW = WRAP_CODE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           adv_x,
    input  logic           adv_y,
    input  blit_dir_t      dir,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  pitch,
    input  logic [WCW-1:0] wx,
    input  logic [WCW-1:0] wy,
    output logic [AW-1:0]  addr
);
    localparam int RW = 1 << WCW;

    typedef struct packed {
        logic [AW-1:0]  line;
        logic [AW-1:0]  col;
        logic [AW-1:0]  col0;
        logic [AW-1:0]  pitch;
        logic [WCW-1:0] wx;
        logic [WCW-1:0] wy;
        logic [RW-1:0]  row;
    } chan_t;

    chan_t st_d, st_q;
    logic [AW-1:0] ld_wmask, ld_tmask, q_wmask, stride, tile_jump, col_n, line_n;
    logic [RW-1:0] ld_hmask, q_hmask;
    logic [WCW:0]  ld_tsh;
    logic          ld_tile, q_tile;

    always_comb begin
        ld_wmask  = (wx != '0) ? ((AW'(1) << wx) - AW'(1)) : '0;
        ld_hmask  = (RW'(1) << wy) - RW'(1);
        ld_tsh    = {1'b0, wx} + {1'b0, wy};
        ld_tmask  = (AW'(1) << ld_tsh) - AW'(1);
        ld_tile   = (wx != '0) && (wy != '0);
        q_wmask   = (st_q.wx != '0) ? ((AW'(1) << st_q.wx) - AW'(1)) : '0;
        q_hmask   = (RW'(1) << st_q.wy) - RW'(1);
        q_tile    = (st_q.wx != '0) && (st_q.wy != '0);
        stride    = st_q.pitch + AW'(1);
        tile_jump = stride << st_q.wy;
        col_n     = dir.neg_x ? (st_q.col - AW'(1)) : (st_q.col + AW'(1));
        line_n    = dir.neg_y ? (st_q.line - stride) : (st_q.line + stride);

        st_d = st_q;
        if (load) begin
            st_d.wx    = wx;
            st_d.wy    = wy;
            st_d.pitch = pitch;
            st_d.col   = base & ld_wmask;
            st_d.col0  = base & ld_wmask;
            st_d.line  = base & ~ld_wmask;
            st_d.row   = '0;
            if (ld_tile) begin
                st_d.row  = RW'(base >> wx) & ld_hmask;
                st_d.line = base & ~ld_tmask;
            end
        end else if (adv_x) begin
            st_d.col = (st_q.wx != '0) ? (col_n & q_wmask) : col_n;
        end else if (adv_y) begin
            st_d.col  = st_q.col0;
            st_d.line = line_n;
            if (q_tile) begin
                if (!dir.neg_y) begin
                    if (st_q.row == q_hmask) begin
                        st_d.row  = '0;
                        st_d.line = line_n - tile_jump;
                    end else begin
                        st_d.row = st_q.row + RW'(1);
                    end
                end else begin
                    if (st_q.row == '0) begin
                        st_d.row  = q_hmask;
                        st_d.line = line_n + tile_jump;
                    end else begin
                        st_d.row = st_q.row - RW'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.line + st_q.col;
endmodule

// File: rtl/blit_addr_stepper.sv
module blit_addr_stepper
    import blit_step_pkg::*;
#(
    parameter int AW  = 16,
    parameter int CW  = 10,
    parameter int WCW = WRAP_CODE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           step,
    input  logic           dir_x_neg,
    input  logic           dir_y_neg,
    input  logic [CW-1:0]  x_last,
    input  logic [CW-1:0]  y_last,
    input  logic [AW-1:0]  dst_base,
    input  logic [AW-1:0]  dst_pitch,
    input  logic [AW-1:0]  src_base,
    input  logic [AW-1:0]  src_pitch,
    input  logic [WCW-1:0] src_wrap_w,
    input  logic [WCW-1:0] src_wrap_h,
    input  logic [AW-1:0]  pat_base,
    input  logic [AW-1:0]  pat_pitch,
    input  logic [WCW-1:0] pat_wrap_w,
    input  logic [WCW-1:0] pat_wrap_h,
    output logic [AW-1:0]  dst_addr,
    output logic [AW-1:0]  src_addr,
    output logic [AW-1:0]  pat_addr,
    output logic           busy,
    output logic           done
);
    blit_dir_t     dir_d, dir_q;
    logic          adv_x, adv_y, neg_x_q;
    logic [AW-1:0] base_a  [NUM_CHAN];
    logic [AW-1:0] pitch_a [NUM_CHAN];
    logic [WCW-1:0] wx_a   [NUM_CHAN];
    logic [WCW-1:0] wy_a   [NUM_CHAN];
    logic [AW-1:0] addr_a  [NUM_CHAN];

    always_comb begin
        dir_d = dir_q;
        if (start) begin
            dir_d.neg_x = dir_x_neg;
            dir_d.neg_y = dir_y_neg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_d;
    end

    assign neg_x_q = dir_q.neg_x;

    always_comb begin
        base_a[CH_DST]  = dst_base;  pitch_a[CH_DST] = dst_pitch;
        wx_a[CH_DST]    = '0;        wy_a[CH_DST]    = '0;
        base_a[CH_SRC]  = src_base;  pitch_a[CH_SRC] = src_pitch;
        wx_a[CH_SRC]    = src_wrap_w; wy_a[CH_SRC]   = src_wrap_h;
        base_a[CH_PAT]  = pat_base;  pitch_a[CH_PAT] = pat_pitch;
        wx_a[CH_PAT]    = pat_wrap_w; wy_a[CH_PAT]   = pat_wrap_h;
    end

    blit_span_ctr #(.CW(CW)) u_span (
        .clk(clk), .rst_n(rst_n), .load(start), .step(step),
        .x_last(x_last), .y_last(y_last),
        .adv_x(adv_x), .adv_y(adv_y), .busy(busy), .done(done)
    );

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        blit_chan #(.AW(AW), .WCW(WCW)) u_chan (
            .clk(clk), .rst_n(rst_n), .load(start),
            .adv_x(adv_x), .adv_y(adv_y), .dir(dir_q),
            .base(base_a[g]), .pitch(pitch_a[g]),
            .wx(wx_a[g]), .wy(wy_a[g]), .addr(addr_a[g])
        );
    end

    assign dst_addr = addr_a[CH_DST];
    assign src_addr = addr_a[CH_SRC];
    assign pat_addr = addr_a[CH_PAT];
endmodule

// File: rtl/blit_addr_stepper_chk.sv
module blit_addr_stepper_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          adv_x,
    input logic          neg_x,
    input logic [AW-1:0] dst_addr,
    input logic [AW-1:0] src_addr,
    input logic [AW-1:0] pat_addr
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy && !done); // R10
    AST_DST_XINC: assert property (@(posedge clk) disable iff (!rst_n) adv_x && !neg_x |=> dst_addr == $past(dst_addr) + AW'(1)); // R3
    AST_DST_XDEC: assert property (@(posedge clk) disable iff (!rst_n) adv_x && neg_x |=> dst_addr == $past(dst_addr) - AW'(1)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && $past(busy)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !busy && !start |=> $stable(dst_addr) && $stable(src_addr) && $stable(pat_addr)); // R9
endmodule

bind blit_addr_stepper blit_addr_stepper_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .adv_x(adv_x), .neg_x(neg_x_q),
    .dst_addr(dst_addr), .src_addr(src_addr), .pat_addr(pat_addr)
);

// File: tb/sim_blit_addr_stepper.sv
module sim_blit_addr_stepper;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16, CW = 10, WCW = 3;

    typedef struct packed {
        logic [15:0] dbase, dpitch, sbase, spitch, pbase, ppitch;
        logic [2:0]  swx, swy, pwx, pwy;
        logic        nx, ny;
        logic [9:0]  xl, yl;
    } cfg_t;

    localparam int NCFG = 7;
    localparam cfg_t CFG [NCFG] = '{
        '{16'h1000, 16'h003F, 16'h2000, 16'h003F, 16'h3000, 16'h0007, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 10'd3, 10'd2},
        '{16'h1000, 16'h0020, 16'h2005, 16'h0010, 16'h3006, 16'h0008, 3'd3, 3'd0, 3'd2, 3'd0, 1'b0, 1'b0, 10'd9, 10'd1},
        '{16'h1010, 16'h0020, 16'h2005, 16'h0010, 16'h3006, 16'h0008, 3'd3, 3'd0, 3'd2, 3'd0, 1'b1, 1'b0, 10'd9, 10'd1},
        '{16'h0400, 16'h001F, 16'h2002, 16'h0003, 16'h3013, 16'h0007, 3'd2, 3'd1, 3'd3, 3'd2, 1'b0, 1'b0, 10'd2, 10'd6},
        '{16'h0800, 16'h001F, 16'h2002, 16'h0003, 16'h3013, 16'h0007, 3'd2, 3'd1, 3'd3, 3'd2, 1'b1, 1'b1, 10'd2, 10'd6},
        '{16'hFFFE, 16'h00FF, 16'h0001, 16'h000F, 16'h0000, 16'h0003, 3'd0, 3'd0, 3'd1, 3'd3, 1'b0, 1'b1, 10'd3, 10'd2},
        '{16'h4321, 16'h0010, 16'h5555, 16'h0010, 16'h6666, 16'h0010, 3'd1, 3'd1, 3'd2, 3'd2, 1'b0, 1'b0, 10'd0, 10'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, step = 1'b0;
    logic dir_x_neg = 1'b0, dir_y_neg = 1'b0;
    logic [CW-1:0] x_last = '0, y_last = '0;
    logic [AW-1:0] dst_base = '0, dst_pitch = '0, src_base = '0, src_pitch = '0;
    logic [AW-1:0] pat_base = '0, pat_pitch = '0;
    logic [WCW-1:0] src_wrap_w = '0, src_wrap_h = '0, pat_wrap_w = '0, pat_wrap_h = '0;
    logic [AW-1:0] dst_addr, src_addr, pat_addr;
    logic busy, done;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blit_addr_stepper #(.AW(AW), .CW(CW), .WCW(WCW)) u0 (.*);

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Closed-form expected address for pixel i of row j.
    function automatic logic [15:0] model(logic [15:0] base, logic [15:0] pitch,
                                          logic [2:0] wx, logic [2:0] wy,
                                          logic nx, logic ny, int i, int j);
        int stride = int'(pitch) + 1;
        int dx = nx ? -i : i;
        int b = int'(base);
        int w, h, col0, col, al, row0, rj, rowpart;
        if (wx == 0) return 16'(b + dx + (ny ? -j : j) * stride);
        w    = 1 << wx;
        col0 = b & (w - 1);
        col  = (col0 + dx) & (w - 1);
        if (wy == 0) begin
            al = b - col0;
            rowpart = (ny ? -j : j) * stride;
        end else begin
            h    = 1 << wy;
            row0 = (b >> wx) & (h - 1);
            al   = b & ~(w * h - 1);
            rj   = (row0 + (ny ? -j : j)) & (h - 1);
            rowpart = stride * (rj - row0);
        end
        return 16'(al + rowpart + col);
    endfunction

    task automatic apply(cfg_t c);
        dst_base = c.dbase; dst_pitch = c.dpitch;
        src_base = c.sbase; src_pitch = c.spitch; src_wrap_w = c.swx; src_wrap_h = c.swy;
        pat_base = c.pbase; pat_pitch = c.ppitch; pat_wrap_w = c.pwx; pat_wrap_h = c.pwy;
        dir_x_neg = c.nx; dir_y_neg = c.ny; x_last = c.xl; y_last = c.yl;
    endtask

    task automatic check_px(cfg_t c, int i, int j, string req);
        chk({req, " dst"}, 32'(dst_addr), 32'(model(c.dbase, c.dpitch, 3'd0, 3'd0, c.nx, c.ny, i, j)));
        chk({req, " src"}, 32'(src_addr), 32'(model(c.sbase, c.spitch, c.swx, c.swy, c.nx, c.ny, i, j)));
        chk({req, " pat"}, 32'(pat_addr), 32'(model(c.pbase, c.ppitch, c.pwx, c.pwy, c.nx, c.ny, i, j)));
    endtask

    // Start (with step high: R10 load priority) and walk every pixel.
    task automatic run_cfg(cfg_t c);
        int n = (int'(c.xl) + 1) * (int'(c.yl) + 1);
        int w = int'(c.xl) + 1;
        @(negedge clk); apply(c); start = 1'b1; step = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R2 busy after start", 32'(busy), 32'd1);
        for (int k = 0; k < n; k++) begin
            check_px(c, k % w, k / w, "R3/R4/R5/R6/R7/R11 pixel");
            @(negedge clk);
        end
        chk("R8 done pulse", 32'(done), 32'd1);
        chk("R8 busy cleared", 32'(busy), 32'd0);
        check_px(c, (n - 1) % w, (n - 1) / w, "R8 hold");
        @(negedge clk);
        chk("R8 done one cycle", 32'(done), 32'd0);
        check_px(c, (n - 1) % w, (n - 1) / w, "R9 idle step");
        step = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 dst reset", 32'(dst_addr), 32'd0);
        chk("R1 busy reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        step = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 R9 src after release", 32'(src_addr), 32'd0);
        chk("R1 R9 pat after release", 32'(pat_addr), 32'd0);
        chk("R1 done after release", 32'(done), 32'd0);
        step = 1'b0;

        // Table walk
        for (int t = 0; t < NCFG; t++) run_cfg(CFG[t]);

        // R10: restart mid rectangle
        @(negedge clk); apply(CFG[0]); start = 1'b1;
        @(negedge clk); start = 1'b0; step = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 busy mid run", 32'(busy), 32'd1);
        run_cfg(CFG[3]);

        // R9: long idle stepping
        step = 1'b1;
        repeat (4) @(negedge clk);
        check_px(CFG[3], 2, 6, "R9 idle hold");
        chk("R9 busy stays low", 32'(busy), 32'd0);
        step = 1'b0;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule